// File: doc/BRIEF.md
# Low-Power Mode Controller

This block picks the processor's low-power state when a sleep instruction retires and brings the processor back to full operation. Two standby-control register values are presented at its inputs. When the sleep strobe arrives while the processor is running, the select bit of each register decides the new state. The first register's bit has priority and chooses standby. Failing that, the second register's bit chooses deep sleep. With neither bit set, plain sleep is chosen.

The current state is held in a single register. Three run enables are decoded from it: one for the core clock, one for the DMA controller, and one shared by the timer, serial and power-management peripherals. A pending interrupt returns any low-power state to running on the next clock edge. An asynchronous reset forces running at once.

Top module: `lpm_ctrl`

## Requirements
- R1: Out of reset the mode code is 00 (running) and all three run enables are high.
- R2: A sleep strobe seen in running while bit 7 of `stby_cfg_a` is set makes the mode 11 (standby) on the next edge, whatever `stby_cfg_b` holds.
- R3: A sleep strobe seen in running with bit 7 of `stby_cfg_a` clear and bit 7 of `stby_cfg_b` set makes the mode 10 (deep sleep) on the next edge.
- R4: A sleep strobe seen in running with bit 7 of both registers clear makes the mode 01 (sleep) on the next edge. Bits 6..0 of both registers have no effect on the choice.
- R5: In any low-power mode (01, 10, 11), a high `irq_pending` at an edge makes the mode 00 on that edge.
- R6: In a low-power mode without `irq_pending`, the sleep strobe and the register values are ignored and the mode stays unchanged.
- R7: `core_run_o` is high in mode 00 and low in every other mode.
- R8: `dma_run_o` is low in modes 10 and 11 and high in modes 00 and 01.
- R9: `periph_run_o` is low only in mode 11.
- R10: Asserting `rst_n` low in any mode forces mode 00 without waiting for a clock edge.
- R11: In running, `irq_pending` has no effect: alone it leaves the mode at 00, and together with a sleep strobe the mode still moves to the state chosen by R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle strobe from a retiring sleep instruction |
| stby_cfg_a | input | 8 | First standby-control register value; bit 7 selects standby |
| stby_cfg_b | input | 8 | Second standby-control register value; bit 7 selects deep sleep |
| irq_pending | input | 1 | An interrupt is pending |
| mode_o | output | 2 | Current mode: 00 running, 01 sleep, 10 deep sleep, 11 standby |
| core_run_o | output | 1 | Core clock enable |
| dma_run_o | output | 1 | DMA controller run enable |
| periph_run_o | output | 1 | Timer, serial and power-management run enable |

## Verification
Mode changes from a sleep strobe or a wake interrupt become visible one edge after the input is sampled. The enables are decoded from the registered mode without delay, so they change together with it. The bench drives stimulus on a falling edge and checks on the next falling edge, after exactly one rising edge has passed. Reset acts without a clock, so the R10 check samples one nanosecond after `rst_n` falls, in the middle of a cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        LPM_RUN  = 2'b00,
        LPM_NAP  = 2'b01,
        LPM_DEEP = 2'b10,
        LPM_STBY = 2'b11
    } lpm_mode_e;

    typedef struct packed {
        lpm_mode_e mode;
    } lpm_state_t;

    typedef struct packed {
        logic core;
        logic dma;
        logic periph;
    } lpm_run_t;

endpackage

// File: rtl/lpm_mode_select.sv
module lpm_mode_select
    import lpm_pkg::*;
#(
    parameter int CTRL_W  = 8,
    parameter int SEL_BIT = 7
) (
    input  logic [CTRL_W-1:0] cfg_a,
    input  logic [CTRL_W-1:0] cfg_b,
    output lpm_mode_e         target
);
    // Only the select bit of each register matters; the rest is folded away.
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_a, cfg_b};

    always_comb begin
        if (cfg_a[SEL_BIT])
            target = LPM_STBY;
        else if (cfg_b[SEL_BIT])
            target = LPM_DEEP;
        else
            target = LPM_NAP;
    end
endmodule

// File: rtl/lpm_domain_gate.sv
module lpm_domain_gate
    import lpm_pkg::*;
(
    input  lpm_mode_e mode,
    output lpm_run_t  run
);
    always_comb begin
        run = '{core: 1'b0, dma: 1'b1, periph: 1'b1};
        unique case (mode)
            LPM_RUN:  run.core   = 1'b1;
            LPM_NAP:  ;
            LPM_DEEP: run.dma    = 1'b0;
            LPM_STBY: begin
                run.dma    = 1'b0;
                run.periph = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int CTRL_W  = 8,
    parameter int SEL_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic [CTRL_W-1:0] stby_cfg_a,
    input  logic [CTRL_W-1:0] stby_cfg_b,
    input  logic              irq_pending,
    output logic [1:0]        mode_o,
    output logic              core_run_o,
    output logic              dma_run_o,
    output logic              periph_run_o
);
    lpm_state_t st_d, st_q;
    lpm_mode_e  target;
    lpm_run_t   run;

    lpm_mode_select #(.CTRL_W(CTRL_W), .SEL_BIT(SEL_BIT)) u_sel (
        .cfg_a  (stby_cfg_a),
        .cfg_b  (stby_cfg_b),
        .target (target)
    );

    lpm_domain_gate u_gate (
        .mode (st_q.mode),
        .run  (run)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.mode == LPM_RUN) begin
            if (sleep_req)
                st_d.mode = target;
        end else if (irq_pending) begin
            st_d.mode = LPM_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{mode: LPM_RUN};
        else
            st_q <= st_d;
    end

    assign mode_o       = st_q.mode;
    assign core_run_o   = run.core;
    assign dma_run_o    = run.dma;
    assign periph_run_o = run.periph;

    a_r2_standby_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && sleep_req && stby_cfg_a[SEL_BIT]) |=> (mode_o == 2'b11));

    a_r3_deep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && sleep_req && !stby_cfg_a[SEL_BIT] && stby_cfg_b[SEL_BIT])
        |=> (mode_o == 2'b10));

    a_r5_wake_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b00 && irq_pending) |=> (mode_o == 2'b00));

    a_r6_hold_in_low_power: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b00 && !irq_pending) |=> $stable(mode_o));

    a_r7_core_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        core_run_o |-> (mode_o == 2'b00));

    a_r9_periph_stop_standby: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_run_o |-> (!dma_run_o && !core_run_o));
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [7:0] stby_cfg_a = '0;
    logic [7:0] stby_cfg_b = '0;
    logic       irq_pending = 1'b0;
    logic [1:0] mode_o;
    logic       core_run_o, dma_run_o, periph_run_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    lpm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .stby_cfg_a(stby_cfg_a), .stby_cfg_b(stby_cfg_b),
        .irq_pending(irq_pending), .mode_o(mode_o),
        .core_run_o(core_run_o), .dma_run_o(dma_run_o),
        .periph_run_o(periph_run_o)
    );

    function automatic int exp_mode(logic [7:0] a, logic [7:0] b);
        if (a[7]) return 3;
        if (b[7]) return 2;
        return 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_en(int m);
        chk("R7 core_run",   int'(core_run_o),   (m == 0) ? 1 : 0);
        chk("R8 dma_run",    int'(dma_run_o),    (m < 2) ? 1 : 0);
        chk("R9 periph_run", int'(periph_run_o), (m != 3) ? 1 : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 mode", int'(mode_o), 0);
        chk_en(0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode after release", int'(mode_o), 0);
        chk_en(0);

        for (int ab = 0; ab < 4; ab++) begin
            for (int k = 0; k < 8; k++) begin
                logic [7:0] a, b;
                int m;
                a = {ab[1], 7'(k * 17)};
                b = {ab[0], 7'(k * 37 + 5)};
                m = exp_mode(a, b);

                // entry from running (R2, R3, R4); on k==1 with irq too (R11)
                stby_cfg_a = a;
                stby_cfg_b = b;
                sleep_req  = 1'b1;
                irq_pending = (k == 1);
                @(negedge clk);
                sleep_req = 1'b0;
                irq_pending = 1'b0;
                if (m == 3)      chk("R2 standby entry", int'(mode_o), m);
                else if (m == 2) chk("R3 deep entry", int'(mode_o), m);
                else             chk("R4 sleep entry", int'(mode_o), m);
                if (k == 1) chk("R11 irq with sleep in running", int'(mode_o), m);
                chk_en(m);

                // strobe with opposite settings is ignored (R6)
                stby_cfg_a = ~a;
                stby_cfg_b = ~b;
                sleep_req  = 1'b1;
                @(negedge clk);
                sleep_req = 1'b0;
                chk("R6 strobe ignored", int'(mode_o), m);
                chk_en(m);

                if (k == 3) begin
                    // asynchronous reset mid-cycle (R10)
                    #2 rst_n = 1'b0;
                    #1 chk("R10 async reset", int'(mode_o), 0);
                    chk_en(0);
                    @(negedge clk);
                    rst_n = 1'b1;
                    @(negedge clk);
                end else begin
                    irq_pending = 1'b1;
                    @(negedge clk);
                    irq_pending = 1'b0;
                    chk("R5 wake on irq", int'(mode_o), 0);
                    chk_en(0);
                end

                if (k == 0) begin
                    irq_pending = 1'b1;
                    @(negedge clk);
                    irq_pending = 1'b0;
                    chk("R11 irq alone in running", int'(mode_o), 0);
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule